// File: doc/BRIEF.md
# Bit-Rate Transmit Data Retimer

This block lets a host that has no serial port hand transmit data over one bit at a time. The host places a bit on its data line and strobes it in with a rising edge on its strobe line. The block re-emits the stored bits toward a frequency-shift modulator at a fixed cadence of 1200 bit/s. It generates that cadence internally from a system clock of about 3.58 MHz, using a fractional phase accumulator.

On every bit tick the block samples the host strobe level. If the strobe is high, the host data line drives the modulator bit directly. If the strobe is low, a two-stage retimed path drives the modulator bit, and the block raises a request that tells the host to supply the next bit. The request is an open-drain style pull-down enable. A high strobe level withdraws it. When the transmit mode is not selected, the block holds its state in reset and passes data straight through.

A host that does not want retiming keeps its strobe high at all times.

Top module: `txbit_retimer`

## Requirements
- R1: The first storage stage takes the synchronized host data value only on a rising edge of the synchronized strobe. Data changes without a strobe edge leave it unchanged.
- R2: On each bit tick, the second stage loads the first stage, and the synchronized strobe level is sampled. That sampled level selects the output path until the next tick.
- R3: If the strobe level sampled at the last tick was high, `mod_bit_o` follows `host_data_i` 2 system clocks after the input changes, so the value is correct by the 3rd clock edge.
- R4: If the strobe level sampled at the last tick was low, `mod_bit_o` equals the second stage. Changes on `host_data_i` between ticks do not alter it.
- R5: `rdy_pull_o` goes to 1 (pull the line low, meaning ready) on a tick at which the sampled strobe is low. At the same edge, `mod_bit_o` presents the bit loaded by the previous strobe edge.
- R6: While the synchronized strobe is high, `rdy_pull_o` is 0. It clears no later than the 3rd clock edge after `host_strobe_i` rises.
- R7: Ticks are spaced either floor(CLK_HZ/BIT_HZ) or floor(CLK_HZ/BIT_HZ)+1 system clocks apart, and never occur on two consecutive clocks. With the default 3579545 Hz and 1200 Hz, the mean rate is 1200 Hz.
- R8: While `en_i` is 0, both stages and the request are held cleared, `rdy_pull_o` is 0, and `mod_bit_o` follows `host_data_i` with the R3 latency.
- R9: After reset, `rdy_pull_o` is 0 and the output path is the direct one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (about 3.58 MHz) |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | 1 when the 1200 bit/s transmit mode is selected |
| host_data_i | input | 1 | Host transmit data, asynchronous |
| host_strobe_i | input | 1 | Host bit strobe, asynchronous; held high to bypass retiming |
| mod_bit_o | output | 1 | Data bit to the modulator |
| rdy_pull_o | output | 1 | 1 enables the pull-down of the active-low ready line |

## Verification
The main function is driven with three input patterns.

- **Strobe held high.** Random data shows that the direct path is taken and the request stays off.
- **Full handshake.** Random bits are loaded on request, and the data line is scrambled between strobe edges. This separates edge capture and tick transfer from plain following of the data line. It also measures every tick interval.
- **Disable and mode exit.** The enable is dropped mid-stream, and the strobe is raised just after a tick. These two cases show that the path choice changes only at the next tick, and that disabling clears the request at once.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Output path chosen at each bit tick from the sampled strobe level
    typedef enum logic {
        PATH_RETIMED = 1'b0,
        PATH_DIRECT  = 1'b1
    } path_e;

    // Host lines after synchronization into the system clock domain
    typedef struct packed {
        logic data;
        logic strobe;
    } host_sig_t;

    // Accumulator width able to hold values up to twice the modulus
    function automatic int unsigned acc_bits(input int unsigned modulus);
        return $clog2(modulus) + 1;
    endfunction

endpackage

// File: rtl/txr_sync.sv
module txr_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q;
            logic safe_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= 1'b0;
                    safe_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    safe_q <= meta_q;
                end
            end
            assign sync_o[g] = safe_q;
        end
    endgenerate
endmodule

// File: rtl/txr_tick_gen.sv
module txr_tick_gen
    import txr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned BIT_HZ = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick_o
);
    localparam int unsigned AW = acc_bits(CLK_HZ);
    localparam logic [AW-1:0] STEP = AW'(BIT_HZ);
    localparam logic [AW-1:0] MODV = AW'(CLK_HZ);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;

    assign sum = acc_q + STEP;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (sum >= MODV) begin
            acc_q  <= sum - MODV;
            tick_o <= 1'b1;
        end else begin
            acc_q  <= sum;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/txr_core.sv
module txr_core
    import txr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  host_sig_t host,
    output logic      mod_bit_o,
    output logic      rdy_pull_o,
    output logic      stage2_o,
    output path_e     path_o
);
    logic  strobe_prev_q;
    logic  stage1_q;
    logic  stage2_q;
    path_e path_q;
    logic  rdy_q;
    logic  strobe_rise;

    assign strobe_rise = host.strobe && !strobe_prev_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            strobe_prev_q <= 1'b0;
            stage1_q      <= 1'b0;
            stage2_q      <= 1'b0;
            path_q        <= PATH_DIRECT;
            rdy_q         <= 1'b0;
        end else begin
            strobe_prev_q <= host.strobe;
            if (strobe_rise) begin
                stage1_q <= host.data;
            end
            if (tick) begin
                stage2_q <= stage1_q;
                path_q   <= host.strobe ? PATH_DIRECT : PATH_RETIMED;
            end
            if (host.strobe) begin
                rdy_q <= 1'b0;
            end else if (tick) begin
                rdy_q <= 1'b1;
            end
        end
    end

    assign mod_bit_o  = (path_q == PATH_DIRECT) ? host.data : stage2_q;
    assign rdy_pull_o = rdy_q;
    assign stage2_o   = stage2_q;
    assign path_o     = path_q;
endmodule

// File: rtl/txbit_retimer.sv
module txbit_retimer
    import txr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned BIT_HZ = 1200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic host_data_i,
    input  logic host_strobe_i,
    output logic mod_bit_o,
    output logic rdy_pull_o
);
    logic [1:0] sync_bus;
    host_sig_t  host_s;
    logic       tick_q;
    logic       stage2_q;
    path_e      path_q;

    txr_sync #(.W(2)) u_sync (
        .clk     (clk_i),
        .rst     (rst_i),
        .async_i ({host_strobe_i, host_data_i}),
        .sync_o  (sync_bus)
    );

    assign host_s.data   = sync_bus[0];
    assign host_s.strobe = sync_bus[1];

    txr_tick_gen #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) u_tick (
        .clk    (clk_i),
        .rst    (rst_i),
        .run    (en_i),
        .tick_o (tick_q)
    );

    txr_core u_core (
        .clk        (clk_i),
        .rst        (rst_i),
        .en         (en_i),
        .tick       (tick_q),
        .host       (host_s),
        .mod_bit_o  (mod_bit_o),
        .rdy_pull_o (rdy_pull_o),
        .stage2_o   (stage2_q),
        .path_o     (path_q)
    );
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic tick,
    input logic strobe_s,
    input logic stage2,
    input logic path,
    input logic rdy_pull
);
    // R7: ticks never arrive on consecutive clocks
    p_tick_spaced_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: the request only appears on a tick edge
    p_rdy_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_pull) |-> $past(tick));

    // R6: a high synchronized strobe withdraws the request
    p_strobe_clears_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_s |=> !rdy_pull);

    // R8: disabled mode clears the request and selects the direct path
    p_disabled_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!rdy_pull && path));

    // R2: the second stage moves only on a tick
    p_stage2_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(stage2));

    // R2: the path choice changes only on a tick
    p_path_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(path));
endmodule

bind txbit_retimer txr_checker u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .en       (en_i),
    .tick     (tick_q),
    .strobe_s (host_s.strobe),
    .stage2   (stage2_q),
    .path     (path_q),
    .rdy_pull (rdy_pull_o)
);

// File: tb/txbit_retimer_bench.sv
module txbit_retimer_bench;
    localparam int unsigned CLK_HZ  = 1000;
    localparam int unsigned BIT_HZ  = 37;
    localparam int unsigned PER_LO  = CLK_HZ / BIT_HZ;
    localparam int unsigned PER_HI  = (CLK_HZ % BIT_HZ == 0) ? PER_LO : PER_LO + 1;
    localparam time         CLK_PER = 10ns;

    logic clk = 1'b0;
    logic rst, en, data, strobe;
    logic mod_bit, rdy_pull;
    int   errors = 0;
    int   checks = 0;
    int   cyc    = 0;
    int unsigned seed_v;

    txbit_retimer #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) u_txbit_retimer (
        .clk_i         (clk),
        .rst_i         (rst),
        .en_i          (en),
        .host_data_i   (data),
        .host_strobe_i (strobe),
        .mod_bit_o     (mod_bit),
        .rdy_pull_o    (rdy_pull)
    );

    always #(CLK_PER / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit period_ok(input int d);
        return (d == int'(PER_LO)) || (d == int'(PER_HI));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for the request to appear; returns the cycle stamp or -1 on timeout
    task automatic wait_rdy(output int stamp);
        stamp = -1;
        for (int i = 0; i < 4 * int'(PER_HI); i++) begin
            @(negedge clk);
            if (rdy_pull) begin
                stamp = cyc;
                break;
            end
        end
        if (stamp < 0) check(1'b0, "R5 request timeout", 0, 1);
    endtask

    initial begin
        int  last_stamp, stamp;
        bit  cur, nb;
        bit  cur_known;
        seed_v = $urandom(32'd7011);
        rst = 1'b1; en = 1'b0; data = 1'b0; strobe = 1'b1;
        cycles(5);
        rst = 1'b0;
        cycles(3);
        // R9: reset state
        check(rdy_pull == 1'b0, "R9 rdy after reset", rdy_pull, 0);
        check(mod_bit == 1'b0, "R9 direct path after reset", mod_bit, 0);

        // R8: disabled, random data and strobe toggles
        for (int k = 0; k < 10; k++) begin
            data = 1'($urandom);
            strobe = 1'($urandom);
            cycles(3);
            check(mod_bit == data, "R8 passthrough when disabled", mod_bit, data);
            check(rdy_pull == 1'b0, "R8 no request when disabled", rdy_pull, 0);
        end

        // R3 / R6: enabled, strobe held high
        strobe = 1'b1;
        en = 1'b1;
        for (int k = 0; k < 3 * int'(PER_HI); k++) begin
            data = 1'($urandom);
            cycles(3);
            check(mod_bit == data, "R3 strobe high passthrough", mod_bit, data);
            check(rdy_pull == 1'b0, "R6 no request with strobe high", rdy_pull, 0);
        end

        // Retimed handshake
        strobe = 1'b0;
        wait_rdy(last_stamp);
        cur_known = 1'b0;
        cur = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (cur_known)
                check(mod_bit == cur, "R5 bit presented at request", mod_bit, cur);
            nb = 1'($urandom);
            data = nb;
            strobe = 1'b1;
            cycles(4);
            check(rdy_pull == 1'b0, "R6 strobe high clears request", rdy_pull, 0);
            strobe = 1'b0;
            for (int j = 0; j < 3; j++) begin
                data = 1'($urandom);
                cycles(1);
            end
            if (cur_known)
                check(mod_bit == cur, "R4 data changes ignored between ticks", mod_bit, cur);
            wait_rdy(stamp);
            check(period_ok(stamp - last_stamp), "R7 tick interval", stamp - last_stamp, PER_LO);
            check(mod_bit == nb, "R1 R2 strobed bit retimed out", mod_bit, nb);
            last_stamp = stamp;
            cur = nb;
            cur_known = 1'b1;
        end

        // R2: path stays retimed until the next tick samples strobe high
        strobe = 1'b1;
        data = ~cur;
        cycles(5);
        check(mod_bit == cur, "R2 path held until tick", mod_bit, cur);
        cycles(int'(PER_HI) + 2);
        check(mod_bit == data, "R3 direct path after tick", mod_bit, data);
        for (int k = 0; k < 5; k++) begin
            data = 1'($urandom);
            cycles(3);
            check(mod_bit == data, "R3 passthrough after exit", mod_bit, data);
        end

        // R8: disable in the middle of retiming
        strobe = 1'b0;
        wait_rdy(stamp);
        en = 1'b0;
        cycles(1);
        check(rdy_pull == 1'b0, "R8 disable clears request", rdy_pull, 0);
        data = ~mod_bit;
        cycles(3);
        check(mod_bit == data, "R8 direct path after disable", mod_bit, data);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PER * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule